// File: doc/BRIEF.md
# Raw Ten-Bit Character Aligner

This block frames an undecoded serial stream into 10-bit characters for the case where 8B/10B decoding is switched off. On each clock it takes one 10-bit chunk of deserialized bits, with no known relationship to character boundaries. It keeps the previous chunk, so that all ten possible boundary positions can be examined at once. It looks for a single comma polarity, a character that begins with 0011111. While the resync enable is high, a comma found at a new bit position moves the character boundary so that the comma begins a character. While the enable is low, the boundary stays where it is.

The character is passed through whole, with no decoding. The two upper bits appear on the output in the places a decoder would use for its control and error flags. A comma-detect flag goes with each output character.

Top module: `raw_char_aligner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the boundary offset is 0, `char_out` is 0 and `comma_det` is low.
- R2: Bit 9 of each chunk is the earliest bit in time. A character at offset k is the 10 consecutive bits that start at bit position k of the older chunk, counted from bit 9. Chunk N+1 is sampled at one clock edge. At the next edge, `char_out` shows the character at the current offset taken from chunks N and N+1, which is a latency of 2 clocks.
- R3: While `resync_en` is low, the offset does not change, whatever the data contains.
- R4: `comma_det` is high exactly when bits 9..3 of `char_out` equal 0011111.
- R5: The complementary prefix 1100000 neither sets `comma_det` nor moves the boundary.
- R6: With `resync_en` high, suppose the character at the current offset has no comma and at least one other offset does. The offset then moves to the lowest such offset, and the character output in that same cycle is already the comma taken at the new offset.
- R7: With `resync_en` high, if the character at the current offset has a comma, the offset is kept even when a lower offset also shows one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| resync_en | input | 1 | High allows the boundary to move on a comma |
| rx_chunk | input | 10 | Unaligned 10-bit slice of the serial stream, bit 9 earliest |
| char_out | output | 10 | Aligned raw character |
| comma_det | output | 1 | Output character begins with the comma prefix |

## Verification
Random chunks with the enable low show that the framing passes through unchanged at offset 0. Commas placed 3 bits off the current framing, with the enable high, check that the boundary jumps and that the output is correct in the cycle of the jump. A second shift with the enable low shows that the framing stays frozen while misaligned commas go by. A run of complementary-prefix characters must never be taken as a comma. A stream in which two offsets carry a comma in the same window tells keep-current selection apart from lowest-offset selection.

// File: rtl/rca_pkg.sv
package rca_pkg;
   // how the offset controller reacts when several offsets hold a comma
   typedef enum logic {
      SEL_KEEP_CURRENT = 1'b0,
      SEL_LOWEST       = 1'b1
   } sel_mode_e;
endpackage

// File: rtl/rca_window_scan.sv
module rca_window_scan #(
   parameter int CHAR_W = 10,
   parameter int PFX_W  = 7,
   parameter logic [PFX_W-1:0] PFX = 7'b0011111
) (
   input  logic [2*CHAR_W-1:0]             win,
   output logic [CHAR_W-1:0][CHAR_W-1:0]   cand,
   output logic [CHAR_W-1:0]               hit
);
   localparam int WIN_W = 2*CHAR_W;

   if (PFX_W > CHAR_W) begin : g_bad_pfx
      $error("prefix wider than a character");
   end

   for (genvar k = 0; k < CHAR_W; k++) begin : g_pos
      assign cand[k] = win[WIN_W-1-k -: CHAR_W];
      assign hit[k]  = (cand[k][CHAR_W-1 -: PFX_W] == PFX);
   end
endmodule

// File: rtl/rca_offset_ctrl.sv
module rca_offset_ctrl
   import rca_pkg::*;
#(
   parameter int        CHAR_W = 10,
   parameter int        OFS_W  = 4,
   parameter sel_mode_e MODE   = SEL_KEEP_CURRENT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CHAR_W-1:0] hit,
   output logic [OFS_W-1:0]  ofs_q,
   output logic [OFS_W-1:0]  ofs_eff
);
   logic [OFS_W-1:0] lowest;
   logic             any_hit;

   assign any_hit = |hit;

   always_comb begin
      lowest = '0;
      for (int k = CHAR_W-1; k >= 0; k--) begin
         if (hit[k]) lowest = OFS_W'(k);
      end
   end

   if (MODE == SEL_KEEP_CURRENT) begin : g_keep
      always_comb begin
         ofs_eff = ofs_q;
         if (en && any_hit && !hit[ofs_q]) ofs_eff = lowest;
      end
      // R7: a comma at the current offset pins the framing
      p_keep_current_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (en && hit[ofs_q]) |=> $stable(ofs_q));
   end else begin : g_lowest
      always_comb begin
         ofs_eff = ofs_q;
         if (en && any_hit) ofs_eff = lowest;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ofs_q <= '0;
      else        ofs_q <= ofs_eff;
   end

   p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(ofs_q));
   p_move_needs_comma_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && any_hit) |=> $stable(ofs_q));
   p_ofs_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_q < OFS_W'(CHAR_W));
endmodule

// File: rtl/raw_char_aligner.sv
module raw_char_aligner
   import rca_pkg::*;
#(
   parameter int        CHAR_W = 10,
   parameter int        PFX_W  = 7,
   parameter logic [PFX_W-1:0] PFX = 7'b0011111,
   parameter sel_mode_e MODE   = SEL_KEEP_CURRENT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              resync_en,
   input  logic [CHAR_W-1:0] rx_chunk,
   output logic [CHAR_W-1:0] char_out,
   output logic              comma_det
);
   localparam int OFS_W = (CHAR_W > 2) ? $clog2(CHAR_W) : 1;

   if (CHAR_W < 2) begin : g_bad_width
      $error("character width must be at least 2");
   end

   logic [CHAR_W-1:0]             prev_q, cur_q;
   logic [CHAR_W-1:0][CHAR_W-1:0] cand;
   logic [CHAR_W-1:0]             hit;
   logic [OFS_W-1:0]              ofs_q, ofs_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         cur_q  <= '0;
      end else begin
         prev_q <= cur_q;
         cur_q  <= rx_chunk;
      end
   end

   rca_window_scan #(.CHAR_W(CHAR_W), .PFX_W(PFX_W), .PFX(PFX)) u_scan (
      .win  ({prev_q, cur_q}),
      .cand (cand),
      .hit  (hit)
   );

   rca_offset_ctrl #(.CHAR_W(CHAR_W), .OFS_W(OFS_W), .MODE(MODE)) u_ofs (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (resync_en),
      .hit     (hit),
      .ofs_q   (ofs_q),
      .ofs_eff (ofs_eff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         char_out  <= '0;
         comma_det <= 1'b0;
      end else begin
         char_out  <= cand[ofs_eff];
         comma_det <= hit[ofs_eff];
      end
   end

   // R4: flag and character leave through separate registers and must agree
   p_det_agrees_r4: assert property (@(posedge clk) disable iff (!rst_n)
      comma_det == (char_out[CHAR_W-1 -: PFX_W] == PFX));
   // R5: the opposite polarity never raises the flag
   p_no_complement_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (char_out[CHAR_W-1 -: PFX_W] == ~PFX) |-> !comma_det);
endmodule

// File: tb/raw_char_aligner_test.sv
module raw_char_aligner_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [9:0] din = '0;
   logic [9:0] char_out;
   logic       comma_det;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   raw_char_aligner uut (
      .clk(clk), .rst_n(rst_n), .resync_en(en), .rx_chunk(din),
      .char_out(char_out), .comma_det(comma_det)
   );

   // serial stream and reference state
   bit         sq[$];
   int         pushed = 0;
   bit         fb = 0;
   logic [9:0] mprev = '0, mcur = '0;
   int         mofs = 0;
   logic [9:0] exp_c = '0;
   bit         exp_d = 0;
   string      last_tag = "R1";

   function automatic logic [9:0] mchar(logic [19:0] w, int k);
      logic [9:0] r;
      for (int i = 0; i < 10; i++) r[9-i] = w[19-k-i];
      return r;
   endfunction

   function automatic bit mhit(logic [9:0] c);
      return c[9:3] == 7'b0011111;
   endfunction

   task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic push_char(logic [9:0] c);
      for (int i = 9; i >= 0; i--) begin sq.push_back(c[i]); pushed++; end
   endtask

   task automatic push_fill(int n);
      for (int i = 0; i < n; i++) begin sq.push_back(fb); fb = ~fb; pushed++; end
   endtask

   task automatic step(string tag, logic [9:0] chunk, bit e);
      logic [19:0] w;
      @(negedge clk);
      check(last_tag, char_out, exp_c);
      check("R4", {9'b0, comma_det}, {9'b0, exp_d});
      if (last_tag == "R5") check("R5", {9'b0, comma_det}, 10'b0);
      din = chunk;
      en  = e;
      w = {mprev, mcur};
      if (e && !mhit(mchar(w, mofs))) begin
         for (int k = 9; k >= 0; k--) if (mhit(mchar(w, k))) mofs = k;
      end
      exp_c = mchar(w, mofs);
      exp_d = mhit(exp_c);
      mprev = mcur;
      mcur  = chunk;
      last_tag = tag;
   endtask

   task automatic run_phase(string tag, bit e);
      logic [9:0] c;
      while (sq.size() % 10 != 0) push_fill(1);
      while (sq.size() >= 10) begin
         for (int i = 9; i >= 0; i--) c[i] = sq.pop_front();
         step(tag, c, e);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", char_out, 10'b0);
      check("R1", {9'b0, comma_det}, 10'b0);
      rst_n = 1'b1;

      // R2: random data, framing stays at offset 0
      for (int i = 0; i < 20; i++) push_char(10'($urandom));
      run_phase("R2", 1'b0);

      // R6: commas 3 bits off the current framing
      push_fill(3);
      for (int i = 0; i < 6; i++) begin
         push_char(10'b0011111010);
         push_char(10'b0101010101);
      end
      run_phase("R6", 1'b1);

      // R3: shift again with enable low, framing must not follow
      push_fill(4);
      for (int i = 0; i < 6; i++) begin
         push_char(10'b0011111010);
         push_char(10'($urandom));
      end
      run_phase("R3", 1'b0);

      // R5: complementary prefix only
      for (int i = 0; i < 10; i++) push_char(10'b1100000101);
      run_phase("R5", 1'b1);

      // R7: lock at offset 9, then two commas per window
      while (pushed % 10 != 9) push_fill(1);
      push_char(10'b0011111010);
      push_char(10'b0011111010);
      for (int i = 0; i < 5; i++) begin
         push_char(10'b1100011111);
         push_char(10'b0011111010);
      end
      run_phase("R7", 1'b1);

      push_fill(20);
      run_phase("R2", 1'b0);
      step("R2", 10'b0, 1'b0);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule